// File: doc/BRIEF.md
# Decibel-Step Soft Mute with Zero-Run Analog Mute Request

This block sits in a stereo PCM playback path and scales every incoming sample pair by a common gain. The gain is picked from a ladder of equal 1 dB steps. While the active-low mute control is held low, the gain falls by one step each time a sample arrives, until the output is silent. While the control is high, the gain climbs back one step per sample to unity. The ramp is driven by the level of the control, not by its edges. A reversal in the middle of a ramp therefore turns around at the step already reached, with no jump in gain.

Alongside the scaler, a saturating run counter watches the raw input pairs. After a long unbroken run of pairs in which both channels are zero, it raises a request to engage the downstream analog mute. The same request is raised when the soft mute has reached full attenuation and the mute control is still held low. The first pair with a nonzero channel drops the request and restarts the run count.

All state moves only on the sample strobe. Results are registered on the clock edge that samples the strobe.

Top module: `soft_mute_ramp`

## Requirements
- R1: During reset and after reset is released, with no strobe yet, `left_o`, `right_o`, `busy_o` and `amute_o` are 0, and the gain step is 0 (unity).
- R2: A pair that arrives while the step is 0 appears unchanged on `left_o`/`right_o` after the clock edge that samples the strobe.
- R3: The gain factor for step k (0 <= k < STEPS) is round(2^(GW-1) * 10^(-k/20)). The output is floor((sample * factor + 2^(GW-2)) / 2^(GW-1)), saturated to DW bits. Each pair uses the step held before that strobe. With `mute_n_i` low, each strobe then raises the step by one, up to STEPS.
- R4: At step STEPS (104 by default) the factor is exactly zero, so both outputs are 0. The step never exceeds STEPS.
- R5: With `mute_n_i` high, each strobe lowers the step by one, down to 0. A full ramp in either direction takes STEPS strobes.
- R6: When `mute_n_i` changes in the middle of a ramp, the next strobe moves the step by one from its current value in the new direction.
- R7: `busy_o` is 1 exactly when the step differs from its target: STEPS when `mute_n_i` is low, and 0 when it is high.
- R8: `amute_o` rises on the edge that samples the ZRUN-th consecutive strobe whose left and right inputs are both zero. It is still 0 after ZRUN-1 such strobes.
- R9: A strobe with either input nonzero clears `amute_o`, unless the R10 condition holds, and restarts the zero-run count from 0.
- R10: `amute_o` is 1 after a strobe that leaves the step at STEPS while `mute_n_i` is low.
- R11: Both channels of a pair use the same factor. Equal inputs give equal outputs.
- R12: Without a strobe, the outputs, the step and `amute_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_stb_i | input | 1 | One-cycle strobe marking a new sample pair |
| mute_n_i | input | 1 | Mute control level; low ramps toward silence |
| left_i | input | DW | Left input sample, two's complement |
| right_i | input | DW | Right input sample, two's complement |
| left_o | output | DW | Scaled left sample |
| right_o | output | DW | Scaled right sample |
| busy_o | output | 1 | Gain ramp has not reached its target |
| amute_o | output | 1 | Request to engage the analog mute |

## Verification
The bench builds the block with DW = 16, GW = 16, STEPS left at 104 and ZRUN reduced to 24. The default step count keeps every entry of the true 104-step gain ladder in play, including the exact-zero end step. The shortened zero run lets the bench reach the trip point and the exact release, and check the count restart, within a few dozen pairs. At 16 bits the full-scale extremes fit in the same scenarios. These settings reach both full ramps, reversals in the middle of a ramp, equal-channel pairs and the two separate paths that raise the analog-mute request.

// File: rtl/smz_pkg.sv
package smz_pkg;

   // Q1.frac factor for a k dB cut; the last step of the ladder is exact zero
   function automatic logic [31:0] db_gain(input int k, input int steps, input int frac);
      real r;
      if (k >= steps) return 32'd0;
      r = (2.0 ** frac) * (10.0 ** (-real'(k) / 20.0));
      return 32'($rtoi(r + 0.5));
   endfunction

endpackage

// File: rtl/smz_ramp.sv
module smz_ramp #(
   parameter int STEPS = 104,
   localparam int SW = $clog2(STEPS + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          stb_i,
   input  logic          mute_n_i,
   output logic [SW-1:0] step_o,
   output logic [SW-1:0] step_nxt_o,
   output logic          busy_o
);

   localparam logic [SW-1:0] LAST = SW'(STEPS);

   always_comb begin
      step_nxt_o = step_o;
      if (stb_i) begin
         if (mute_n_i) begin
            if (step_o != '0) step_nxt_o = step_o - SW'(1);
         end else begin
            if (step_o != LAST) step_nxt_o = step_o + SW'(1);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) step_o <= '0;
      else         step_o <= step_nxt_o;
   end

   assign busy_o = mute_n_i ? (step_o != '0) : (step_o != LAST);

   a_r3_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i && !mute_n_i && step_o != LAST |=> step_o == $past(step_o) + SW'(1));

   a_r5_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i && mute_n_i && step_o != '0 |=> step_o == $past(step_o) - SW'(1));

   a_r6_unit_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i |=> (int'(step_o) - int'($past(step_o)) <= 1) &&
                (int'($past(step_o)) - int'(step_o) <= 1));

   a_r4_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i |=> step_o <= LAST);

   a_r12_step_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_i |=> $stable(step_o));

endmodule

// File: rtl/smz_scale.sv
module smz_scale #(
   parameter int DW = 24,
   parameter int GW = 16,
   localparam int PW = DW + GW + 1
) (
   input  logic signed [DW-1:0] smp_i,
   input  logic        [GW-1:0] gain_i,
   output logic signed [DW-1:0] smp_o
);

   localparam logic signed [PW:0] ONE  = (PW+1)'(1);
   localparam logic signed [PW:0] HALF = ONE <<< (GW - 2);
   localparam logic signed [PW:0] MAXV = (ONE <<< (DW - 1)) - ONE;
   localparam logic signed [PW:0] MINV = -MAXV - ONE;

   logic signed [PW-1:0] prod;
   logic signed [PW:0]   rnd;
   logic signed [PW:0]   sh;

   always_comb begin
      prod = smp_i * $signed({1'b0, gain_i});
      rnd  = prod + HALF;
      sh   = rnd >>> (GW - 1);
      if (sh > MAXV)      smp_o = MAXV[DW-1:0];
      else if (sh < MINV) smp_o = MINV[DW-1:0];
      else                smp_o = sh[DW-1:0];
   end

endmodule

// File: rtl/smz_zero_run.sv
module smz_zero_run #(
   parameter int ZRUN = 1024,
   localparam int CW = $clog2(ZRUN + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stb_i,
   input  logic zero_i,
   input  logic hold_i,
   output logic amute_o
);

   logic [CW-1:0] cnt, cnt_nxt;

   always_comb begin
      cnt_nxt = cnt;
      if (stb_i) begin
         if (!zero_i)                cnt_nxt = '0;
         else if (cnt != CW'(ZRUN))  cnt_nxt = cnt + CW'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt     <= '0;
         amute_o <= 1'b0;
      end else begin
         cnt <= cnt_nxt;
         if (stb_i) amute_o <= (cnt_nxt == CW'(ZRUN)) || hold_i;
      end
   end

   a_r8_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i && zero_i && cnt == CW'(ZRUN - 1) |=> amute_o);

   a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i && !zero_i && !hold_i |=> !amute_o && cnt == '0);

   a_r12_amute_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_i |=> $stable(amute_o) && $stable(cnt));

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
   parameter int DW    = 24,
   parameter int GW    = 16,
   parameter int STEPS = 104,
   parameter int ZRUN  = 1024
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 smp_stb_i,
   input  logic                 mute_n_i,
   input  logic signed [DW-1:0] left_i,
   input  logic signed [DW-1:0] right_i,
   output logic signed [DW-1:0] left_o,
   output logic signed [DW-1:0] right_o,
   output logic                 busy_o,
   output logic                 amute_o
);

   localparam int SW = $clog2(STEPS + 1);
   localparam int NCH = 2;

   if (DW < 8 || DW > 32) begin : g_bad_dw
      $error("soft_mute_ramp: DW out of range");
   end
   if (GW < 8 || GW > 24) begin : g_bad_gw
      $error("soft_mute_ramp: GW out of range");
   end
   if (STEPS < 2 || STEPS > 255) begin : g_bad_steps
      $error("soft_mute_ramp: STEPS out of range");
   end
   if (ZRUN < 2) begin : g_bad_zrun
      $error("soft_mute_ramp: ZRUN too small");
   end

   // gain ladder, computed at elaboration
   logic [GW-1:0] gtab [0:STEPS];
   for (genvar k = 0; k <= STEPS; k++) begin : g_tab
      localparam logic [GW-1:0] GV = GW'(smz_pkg::db_gain(k, STEPS, GW - 1));
      assign gtab[k] = GV;
   end

   logic [SW-1:0] step, step_nxt;
   logic [GW-1:0] gain_cur;

   smz_ramp #(.STEPS(STEPS)) u_ramp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stb_i      (smp_stb_i),
      .mute_n_i   (mute_n_i),
      .step_o     (step),
      .step_nxt_o (step_nxt),
      .busy_o     (busy_o)
   );

   assign gain_cur = gtab[step];

   logic signed [DW-1:0] ch_in [NCH];
   logic signed [DW-1:0] ch_sc [NCH];
   logic signed [DW-1:0] ch_q  [NCH];

   assign ch_in[0] = left_i;
   assign ch_in[1] = right_i;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      smz_scale #(.DW(DW), .GW(GW)) u_scale (
         .smp_i  (ch_in[c]),
         .gain_i (gain_cur),
         .smp_o  (ch_sc[c])
      );
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        ch_q[c] <= '0;
         else if (smp_stb_i) ch_q[c] <= ch_sc[c];
      end
   end

   assign left_o  = ch_q[0];
   assign right_o = ch_q[1];

   logic pair_zero, hold_mute;
   assign pair_zero = (left_i == '0) && (right_i == '0);
   assign hold_mute = (step_nxt == SW'(STEPS)) && !mute_n_i;

   smz_zero_run #(.ZRUN(ZRUN)) u_zrun (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .stb_i   (smp_stb_i),
      .zero_i  (pair_zero),
      .hold_i  (hold_mute),
      .amute_o (amute_o)
   );

   a_r2_unity: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_stb_i && step == '0 |=> left_o == $past(left_i) && right_o == $past(right_i));

   a_r4_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_stb_i && step == SW'(STEPS) |=> left_o == '0 && right_o == '0);

   a_r11_same_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_stb_i && left_i == right_i |=> left_o == right_o);

   a_r10_held_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_stb_i && !mute_n_i && step == SW'(STEPS) |=> amute_o);

   a_r12_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !smp_stb_i |=> $stable(left_o) && $stable(right_o));

endmodule

// File: tb/soft_mute_ramp_tb_top.sv
module soft_mute_ramp_tb_top;

   localparam int DW = 16, GW = 16, STEPS = 104, ZRUN = 24;

   logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, mute_n = 1'b1;
   logic signed [DW-1:0] lin = '0, rin = '0;
   logic signed [DW-1:0] lout, rout;
   logic busy, amute;

   always #4 clk = ~clk;

   soft_mute_ramp #(.DW(DW), .GW(GW), .STEPS(STEPS), .ZRUN(ZRUN)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .smp_stb_i(stb), .mute_n_i(mute_n),
      .left_i(lin), .right_i(rin), .left_o(lout), .right_o(rout),
      .busy_o(busy), .amute_o(amute));

   typedef struct packed {
      logic signed [DW-1:0] l;
      logic signed [DW-1:0] r;
      logic busy;
      logic am;
   } exp_t;

   exp_t  q[$];
   string tq[$];
   int n_run = 0, n_fail = 0;
   int step_m = 0, zc_m = 0;
   bit am_m = 0, done = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int gain_m(input int k);
      if (k >= STEPS) return 0;
      return $rtoi((2.0 ** (GW - 1)) * $pow(10.0, -real'(k) / 20.0) + 0.5);
   endfunction

   function automatic logic signed [DW-1:0] scale_m(input logic signed [DW-1:0] s, input int g);
      longint p, mx, mn;
      mx = (longint'(1) <<< (DW - 1)) - 1;
      mn = -mx - 1;
      p = (longint'(s) * longint'(g) + (longint'(1) <<< (GW - 2))) >>> (GW - 1);
      if (p > mx) p = mx;
      if (p < mn) p = mn;
      return p[DW-1:0];
   endfunction

   task automatic send(input logic signed [DW-1:0] l, input logic signed [DW-1:0] r,
                       input logic mn, input string tag);
      exp_t e;
      int g;
      g = gain_m(step_m);
      e.l = scale_m(l, g);
      e.r = scale_m(r, g);
      if (mn) begin if (step_m > 0) step_m--; end
      else    begin if (step_m < STEPS) step_m++; end
      if (l == 0 && r == 0) begin if (zc_m < ZRUN) zc_m++; end
      else zc_m = 0;
      am_m = (zc_m >= ZRUN) || (step_m == STEPS && !mn);
      e.busy = mn ? (step_m != 0) : (step_m != STEPS);
      e.am = am_m;
      q.push_back(e);
      tq.push_back(tag);
      @(negedge clk);
      lin = l; rin = r; mute_n = mn; stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: compare at the negedge after the sampling edge, then check the hold
   always @(posedge clk) begin
      if (rst_n && stb) begin
         exp_t e;
         string t;
         logic signed [DW-1:0] l0, r0;
         logic a0;
         @(negedge clk);
         e = q.pop_front();
         t = tq.pop_front();
         chk(lout == e.l, t, "left_o", lout, e.l);
         chk(rout == e.r, t, "right_o", rout, e.r);
         chk(busy == e.busy, "R7", {t, " busy_o"}, busy, e.busy);
         chk(amute == e.am, t, "amute_o", amute, e.am);
         l0 = lout; r0 = rout; a0 = amute;
         @(negedge clk);
         chk(lout == l0 && rout == r0 && amute == a0, "R12", "hold without strobe",
             {lout, rout}, {l0, r0});
      end
   end

   initial begin
      #(100000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(lout == 0 && rout == 0, "R1", "outputs in reset", {lout, rout}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(lout == 0 && rout == 0, "R1", "outputs after reset", {lout, rout}, 0);
      chk(busy == 0, "R1", "busy_o after reset", busy, 0);
      chk(amute == 0, "R1", "amute_o after reset", amute, 0);

      // unity path with extremes
      send(16'sd1000, -16'sd1000, 1'b1, "R2");
      send(16'sd32767, -16'sd32768, 1'b1, "R2");
      send(-16'sd1, 16'sd1, 1'b1, "R2");

      // full mute ramp, then held at silence
      for (int i = 0; i < STEPS + 4; i++)
         send(DW'(20000 - i * 37), DW'(-12000 + i * 53), 1'b0, (i < STEPS) ? "R3" : "R10");
      send(16'sd32767, -16'sd32768, 1'b0, "R4");

      // full unmute ramp
      for (int i = 0; i < STEPS + 4; i++)
         send(DW'(-30000 + i * 211), DW'(7777 - i * 19), 1'b1, "R5");

      // reversals mid-ramp
      for (int i = 0; i < 20; i++) send(DW'(15000 + i), DW'(-15000 - i), 1'b0, "R6");
      for (int i = 0; i < 8; i++)  send(DW'(15000 + i), DW'(-15000 - i), 1'b1, "R6");
      for (int i = 0; i < 6; i++)  send(DW'(-9000), DW'(9000), 1'b0, "R6");
      for (int i = 0; i < 22; i++) send(DW'(12345), DW'(12345), 1'b1, "R11");
      for (int i = 0; i < 12; i++) send(DW'(-32768), DW'(-32768), 1'b0, "R11");
      for (int i = 0; i < 14; i++) send(DW'(321), DW'(-321), 1'b1, "R6");

      // zero run trip, release and restart
      for (int i = 0; i < ZRUN + 3; i++) send('0, '0, 1'b1, "R8");
      send(DW'(5), '0, 1'b1, "R9");
      for (int i = 0; i < ZRUN - 1; i++) send('0, '0, 1'b1, "R9");
      send('0, DW'(-1), 1'b1, "R9");
      for (int i = 0; i < ZRUN; i++) send('0, '0, 1'b1, "R8");

      repeat (4) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule